// File: doc/BRIEF.md
# Scanline Playfield Bit Serializer

This block produces the coarse background playfield of a video generator that builds each scanline on the fly, one colour clock at a time. A free-running horizontal counter steps through a 228-clock line: the first 68 clocks are horizontal blank and the remaining 160 are visible pixels. Three CPU-writable pattern registers together hold 20 playfield bits. Each bit is widened to 4 pixels and drives the left half of the line. The right half either repeats those 20 bits or mirrors them.

Every clock the block outputs a one-bit playfield pixel, a visible-region flag and a flag marking the right half of the line. A downstream mixer uses these to pick colours and priorities, for example to colour each half differently. Register writes take effect on the very next clock. Software can therefore rewrite a register midway through a line and get a different pattern in the right half.

Top module: `pf_serializer`

## Requirements
- R1: The horizontal position counts 0 to 227 and wraps to 0, so every line is exactly 228 clocks long. After reset is released, the first clock of the line is position 0.
- R2: `visible_o` is 1 exactly at positions 68 to 227 and 0 at positions 0 to 67.
- R3: `pf_pixel_o` is 0 whenever `visible_o` is 0.
- R4: Visible pixel p (p = position - 68) shows playfield bit p/4, so each bit spans 4 consecutive pixels.
- R5: Left playfield bits 0 to 19 are, in order: pattern register A (select 0) data bits 4, 5, 6, 7; then register B (select 1) bits 7 down to 0; then register C (select 2) bits 0 up to 7.
- R6: Data bits 3:0 of a write to register A have no effect. A write with select value 3 changes no register.
- R7: With `reflect_i` = 0, playfield bit 20+j equals left bit j for j = 0..19.
- R8: With `reflect_i` = 1, playfield bit 20+j equals left bit 19-j, so the right half starts at register C bit 7 and ends at register A bit 4.
- R9: `right_half_o` is 1 for visible pixels 80 to 159 and 0 elsewhere, including during blank.
- R10: A write applied at a clock edge changes the pixel output from that edge onward, so a register rewritten at the middle of a line alters the right half of that same line.
- R11: Asserting `rst_ni` low clears the counter and all three pattern registers; all outputs are 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Colour clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = none |
| wr_data_i | input | 8 | Write data |
| reflect_i | input | 1 | 0 = right half repeats, 1 = right half mirrors |
| pf_pixel_o | output | 1 | Playfield pixel for the current clock |
| visible_o | output | 1 | High during the 160 visible clocks |
| right_half_o | output | 1 | High during visible pixels 80 to 159 |

## Verification
On every cycle, the assertions check that the counter steps and wraps, that blank forces a dark pixel, and where the visible and right-half flags rise. They also check that the pixel holds within a 4-pixel bit cell when no write or reflect change intervenes. Only the bench scenarios can show bit ordering and mirroring, because those depend on register contents. They cover single-bit patterns that locate each register's bits in both halves, the ignored low nibble and unused select, a mid-line rewrite, and the cleared state after reset.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int LINE_CLKS   = 228;
  localparam int HBLANK_CLKS = 68;
  localparam int PIX_PER_BIT = 4;
  localparam int PF_BITS     = 40;
  localparam int HALF_BITS   = PF_BITS / 2;
  localparam int CNT_W       = $clog2(LINE_CLKS);
  localparam int BIT_W       = $clog2(PF_BITS);
  localparam int HIDX_W      = $clog2(HALF_BITS);

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_NONE = 2'd3
  } pf_sel_e;
endpackage

// File: rtl/pf_hcounter.sv
module pf_hcounter #(
  parameter int LINE_CLKS   = pf_pkg::LINE_CLKS,
  parameter int HBLANK_CLKS = pf_pkg::HBLANK_CLKS,
  parameter int PIX_PER_BIT = pf_pkg::PIX_PER_BIT,
  parameter int CNT_W       = $clog2(LINE_CLKS),
  parameter int BIT_W       = pf_pkg::BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] hcnt_o,
  output logic             visible_o,
  output logic [BIT_W-1:0] bit_idx_o
);
  logic [CNT_W-1:0] hcnt_q;
  logic [CNT_W-1:0] pix;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              hcnt_q <= '0;
    else if (hcnt_q == CNT_W'(LINE_CLKS - 1)) hcnt_q <= '0;
    else                                      hcnt_q <= hcnt_q + CNT_W'(1);
  end

  always_comb begin
    visible_o = (hcnt_q >= CNT_W'(HBLANK_CLKS));
    pix       = hcnt_q - CNT_W'(HBLANK_CLKS);
    // index forced to 0 in blank so downstream never selects out of range
    bit_idx_o = visible_o ? BIT_W'(pix / CNT_W'(PIX_PER_BIT)) : '0;
  end

  assign hcnt_o = hcnt_q;
endmodule

// File: rtl/pf_regs.sv
module pf_regs #(
  parameter int HALF_BITS = pf_pkg::HALF_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [7:0]           wr_data_i,
  output logic [HALF_BITS-1:0] seq_o
);
  import pf_pkg::*;

  localparam int A_BITS = 4;
  localparam int B_BITS = 8;
  localparam int C_BITS = 8;
  localparam int B_BASE = A_BITS;
  localparam int C_BASE = A_BITS + B_BITS;

  logic [A_BITS-1:0] reg_a_q;  // upper nibble only
  logic [B_BITS-1:0] reg_b_q;
  logic [C_BITS-1:0] reg_c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= '0;
      reg_b_q <= '0;
      reg_c_q <= '0;
    end else if (wr_en_i) begin
      case (pf_sel_e'(wr_sel_i))
        SEL_A:   reg_a_q <= wr_data_i[7:4];
        SEL_B:   reg_b_q <= wr_data_i;
        SEL_C:   reg_c_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // A ascending, B descending, C ascending
  for (genvar g = 0; g < HALF_BITS; g++) begin : g_seq
    if (g < B_BASE) begin : g_a
      assign seq_o[g] = reg_a_q[g];
    end else if (g < C_BASE) begin : g_b
      assign seq_o[g] = reg_b_q[B_BITS-1-(g-B_BASE)];
    end else begin : g_c
      assign seq_o[g] = reg_c_q[g-C_BASE];
    end
  end
endmodule

// File: rtl/pf_bit_mux.sv
module pf_bit_mux #(
  parameter int PF_BITS   = pf_pkg::PF_BITS,
  parameter int HALF_BITS = PF_BITS / 2,
  parameter int BIT_W     = $clog2(PF_BITS),
  parameter int HIDX_W    = $clog2(HALF_BITS)
) (
  input  logic [HALF_BITS-1:0] seq_i,
  input  logic [BIT_W-1:0]     bit_idx_i,
  input  logic                 visible_i,
  input  logic                 reflect_i,
  output logic                 pixel_o,
  output logic                 right_half_o
);
  logic             right;
  logic [BIT_W-1:0] k_w;
  logic [HIDX_W-1:0] k;

  always_comb begin
    right = (bit_idx_i >= BIT_W'(HALF_BITS));
    if (!right)         k_w = bit_idx_i;
    else if (reflect_i) k_w = BIT_W'(PF_BITS - 1) - bit_idx_i;
    else                k_w = bit_idx_i - BIT_W'(HALF_BITS);
    k            = HIDX_W'(k_w);
    pixel_o      = visible_i & seq_i[k];
    right_half_o = visible_i & right;
  end
endmodule

// File: rtl/pf_serializer.sv
module pf_serializer #(
  parameter int LINE_CLKS   = pf_pkg::LINE_CLKS,
  parameter int HBLANK_CLKS = pf_pkg::HBLANK_CLKS,
  parameter int PIX_PER_BIT = pf_pkg::PIX_PER_BIT,
  parameter int PF_BITS     = pf_pkg::PF_BITS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       reflect_i,
  output logic       pf_pixel_o,
  output logic       visible_o,
  output logic       right_half_o
);
  localparam int CNT_W     = $clog2(LINE_CLKS);
  localparam int HALF_BITS = PF_BITS / 2;
  localparam int BIT_W     = $clog2(PF_BITS);
  localparam int HIDX_W    = $clog2(HALF_BITS);

  logic [CNT_W-1:0]     hcnt_q;
  logic [BIT_W-1:0]     bit_idx;
  logic [HALF_BITS-1:0] seq;
  logic                 vis;

  pf_hcounter #(
    .LINE_CLKS(LINE_CLKS), .HBLANK_CLKS(HBLANK_CLKS),
    .PIX_PER_BIT(PIX_PER_BIT), .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_hcnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hcnt_o(hcnt_q), .visible_o(vis), .bit_idx_o(bit_idx)
  );

  pf_regs #(.HALF_BITS(HALF_BITS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .seq_o(seq)
  );

  pf_bit_mux #(
    .PF_BITS(PF_BITS), .HALF_BITS(HALF_BITS), .BIT_W(BIT_W), .HIDX_W(HIDX_W)
  ) u_mux (
    .seq_i(seq), .bit_idx_i(bit_idx), .visible_i(vis), .reflect_i(reflect_i),
    .pixel_o(pf_pixel_o), .right_half_o(right_half_o)
  );

  assign visible_o = vis;
endmodule

// File: rtl/pf_serializer_checker.sv
module pf_serializer_checker #(
  parameter int LINE_CLKS   = pf_pkg::LINE_CLKS,
  parameter int HBLANK_CLKS = pf_pkg::HBLANK_CLKS,
  parameter int PIX_PER_BIT = pf_pkg::PIX_PER_BIT,
  parameter int CNT_W       = $clog2(LINE_CLKS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] hcnt_q,
  input logic             wr_en_i,
  input logic             reflect_i,
  input logic             visible_o,
  input logic             pf_pixel_o,
  input logic             right_half_o
);
  localparam int MID_POS = HBLANK_CLKS + (LINE_CLKS - HBLANK_CLKS) / 2;

  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q == CNT_W'(LINE_CLKS - 1) |=> hcnt_q == '0);

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q != CNT_W'(LINE_CLKS - 1) |=> hcnt_q == $past(hcnt_q) + CNT_W'(1));

  assert_vis_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(visible_o) |-> hcnt_q == CNT_W'(HBLANK_CLKS));

  assert_blank_dark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !visible_o |-> !pf_pixel_o);

  assert_cell_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    visible_o && $past(visible_o) && !$past(wr_en_i) && $stable(reflect_i) &&
    ((hcnt_q - CNT_W'(HBLANK_CLKS)) % CNT_W'(PIX_PER_BIT)) != '0
    |-> $stable(pf_pixel_o));

  assert_half_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !visible_o |-> !right_half_o);

  assert_half_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(right_half_o) |-> hcnt_q == CNT_W'(MID_POS));
endmodule

bind pf_serializer pf_serializer_checker #(
  .LINE_CLKS(LINE_CLKS), .HBLANK_CLKS(HBLANK_CLKS), .PIX_PER_BIT(PIX_PER_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hcnt_q(hcnt_q), .wr_en_i(wr_en_i),
  .reflect_i(reflect_i), .visible_o(visible_o), .pf_pixel_o(pf_pixel_o),
  .right_half_o(right_half_o)
);

// File: tb/pf_serializer_bench.sv
module pf_serializer_bench;
  localparam int LINE = 228;
  localparam int HB   = 68;

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  c;
    logic        refl;
    logic [39:0] pat;
  } vec_t;

  // pat bit k = expected playfield bit k
  localparam vec_t VECS [8] = '{
    '{8'h10, 8'h00, 8'h00, 1'b0, 40'h0000100001},  // A bit4 -> 0,20
    '{8'h10, 8'h00, 8'h00, 1'b1, 40'h8000000001},  // A bit4 -> 0,39
    '{8'h00, 8'h80, 8'h00, 1'b0, 40'h0001000010},  // B bit7 -> 4,24
    '{8'h00, 8'h00, 8'h80, 1'b1, 40'h0000180000},  // C bit7 -> 19,20
    '{8'h0F, 8'h00, 8'h00, 1'b0, 40'h0000000000},  // A low nibble ignored
    '{8'h00, 8'h01, 8'h00, 1'b1, 40'h0010000800},  // B bit0 -> 11,28
    '{8'hF0, 8'hFF, 8'hFF, 1'b1, 40'hFFFFFFFFFF},
    '{8'h00, 8'h00, 8'h01, 1'b0, 40'h0100001000}   // C bit0 -> 12,32
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       reflect_i = 1'b0;
  logic       pf_pixel_o, visible_o, right_half_o;

  int total = 0;
  int bad   = 0;
  int pos   = 0;
  logic [7:0] m_a = 0, m_b = 0, m_c = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pf_serializer u_pf_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .reflect_i(reflect_i), .pf_pixel_o(pf_pixel_o),
    .visible_o(visible_o), .right_half_o(right_half_o)
  );

  function automatic logic model_pix(int p);
    logic [19:0] l;
    int b;
    if (p < HB) return 1'b0;
    for (int k = 0; k < 4; k++) l[k] = m_a[4+k];
    for (int k = 0; k < 8; k++) l[4+k] = m_b[7-k];
    for (int k = 0; k < 8; k++) l[12+k] = m_c[k];
    b = (p - HB) / 4;
    if (b < 20) return l[b];
    return reflect_i ? l[39-b] : l[b-20];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pos=%0d act=%0b exp=%0b", tag, pos, act, exp);
    end
  endtask

  // called at negedge; drives for one edge, returns at next negedge
  task automatic tick(bit en, logic [1:0] sel, logic [7:0] d);
    wr_en_i = en; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk_i);
    if (en) begin
      if (sel == 2'd0) m_a = d;
      else if (sel == 2'd1) m_b = d;
      else if (sel == 2'd2) m_c = d;
    end
    pos = (pos + 1) % LINE;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic check_flags();
    check("R1/R2 visible", visible_o, pos >= HB);
    check("R9 right half", right_half_o, pos >= HB + 80);
  endtask

  task automatic line_vs_pat(vec_t v);
    for (int i = 0; i < LINE; i++) begin
      tick(0, 2'd0, 8'h00);
      check_flags();
      if (pos < HB) check("R3 blank dark", pf_pixel_o, 1'b0);
      else check(v.refl ? "R4/R5/R8 mirror" : "R4/R5/R6/R7 repeat",
                 pf_pixel_o, v.pat[(pos - HB) / 4]);
    end
  endtask

  task automatic line_vs_model(string tag);
    for (int i = 0; i < LINE; i++) begin
      tick(0, 2'd0, 8'h00);
      check(tag, pf_pixel_o, model_pix(pos));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: outputs dark while held in reset
    repeat (3) @(negedge clk_i);
    check("R11 reset pixel", pf_pixel_o, 1'b0);
    check("R11 reset visible", visible_o, 1'b0);
    check("R11 reset half", right_half_o, 1'b0);
    rst_ni = 1'b1;
    pos = 0;

    // R1: first 68 clocks blank, then visible, wrap back
    for (int i = 0; i < HB - 1; i++) tick(0, 2'd0, 8'h00);
    check("R2 last blank", visible_o, 1'b0);
    tick(0, 2'd0, 8'h00);
    check("R2 first visible", visible_o, 1'b1);
    for (int i = 0; i < LINE - HB - 1; i++) tick(0, 2'd0, 8'h00);
    check("R1 pos 227 visible", visible_o, 1'b1);
    tick(0, 2'd0, 8'h00);
    check("R1 wrap to blank", visible_o, 1'b0);

    // vector table
    foreach (VECS[n]) begin
      tick(1, 2'd0, VECS[n].a);
      tick(1, 2'd1, VECS[n].b);
      tick(1, 2'd2, VECS[n].c);
      reflect_i = VECS[n].refl;
      line_vs_pat(VECS[n]);
    end

    // R6: select 3 writes nothing
    reflect_i = 1'b0;
    tick(1, 2'd0, 8'h00);
    tick(1, 2'd1, 8'h00);
    tick(1, 2'd2, 8'h00);
    tick(1, 2'd3, 8'hFF);
    line_vs_model("R6 select 3 ignored");

    // R10: mid-line rewrite changes right half immediately
    tick(1, 2'd0, 8'hF0);
    tick(1, 2'd1, 8'hFF);
    tick(1, 2'd2, 8'hFF);
    while (pos != HB + 79) tick(0, 2'd0, 8'h00);
    check("R10 before rewrite", pf_pixel_o, 1'b1);
    tick(1, 2'd0, 8'h00);
    check("R10 rewrite next clock", pf_pixel_o, 1'b0);
    for (int i = 0; i < 16; i++) begin
      tick(0, 2'd0, 8'h00);
      check("R10 right half updated", pf_pixel_o, model_pix(pos));
    end
    line_vs_model("R10 line after rewrite");

    // R11: reset mid-line clears registers and counter
    while (pos != 150) tick(0, 2'd0, 8'h00);
    rst_ni = 1'b0;
    #1;
    check("R11 async reset pixel", pf_pixel_o, 1'b0);
    check("R11 async reset visible", visible_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pos = 0; m_a = 0; m_b = 0; m_c = 0;
    for (int i = 0; i < LINE; i++) begin
      check("R11 cleared pattern", pf_pixel_o, 1'b0);
      check("R11 counter restarted", visible_o, pos >= HB);
      tick(0, 2'd0, 8'h00);
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule